// File: doc/BRIEF.md
# Operand Address Generator with Post-Increment and Bit Reversal

This block turns index-register values into memory addresses for the operand ports of a processor datapath. For each port it receives the current index value and two per-operand flags. One flag asks for a post-increment, the other for a bit-reversed address. The block returns the address to drive to memory and the value to write back into the index register. All ports are evaluated combinationally in the same cycle and do not affect one another.

Two configuration registers are shared by all ports: the step added on a post-increment and the number of low-order address bits that a reversed access mirrors. Each register is loaded on a clock edge by its own write enable. Reversal changes only the address that goes to memory. The write-back value is always derived from the index as it was presented, so the same index sequence can be walked in natural order and read in reversed order, as an FFT reordering pass needs.

Top module: `opaddr_unit`

## Requirements
- R1: After reset the step register holds 1 and the reversal width holds 0, so a reversed access returns the index unchanged and a post-increment adds 1.
- R2: When a port's post-increment flag is low, its write-back output equals its index input.
- R3: When a port's post-increment flag is high, its write-back output equals index plus step, modulo 2^ADDR_W.
- R4: The step register takes `cfg_step_data` on a rising clock edge with `cfg_step_we` high and keeps its value otherwise.
- R5: When a port's reverse flag is low, its address output equals its index input.
- R6: When the reverse flag is high and the effective width n is 2 or more, address bit i equals index bit n-1-i for every i below n.
- R7: With the reverse flag high, address bits at positions n and above equal the index bits at the same positions.
- R8: A reversal width of 0 or 1 gives an address equal to the index, even with the reverse flag high.
- R9: A programmed width above ADDR_W acts as ADDR_W, mirroring the whole address.
- R10: The reverse flag never changes the write-back output; write-back is computed from the unreversed index.
- R11: The width register takes `cfg_width_data` on a rising clock edge with `cfg_width_we` high and keeps its value otherwise.
- R12: All ports share the configuration but each port's outputs depend only on its own index and flags, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_step_we | input | 1 | Load enable for the post-increment step |
| cfg_step_data | input | ADDR_W | New post-increment step |
| cfg_width_we | input | 1 | Load enable for the reversal width |
| cfg_width_data | input | CNT_W | New reversal width (values above ADDR_W saturate) |
| idx_in | input | NPORT*ADDR_W | Index values, port p in bits [p*ADDR_W +: ADDR_W] |
| post_inc | input | NPORT | Per-port post-increment flag, bit p for port p |
| rev_en | input | NPORT | Per-port reverse flag, bit p for port p |
| mem_addr | output | NPORT*ADDR_W | Address to memory, same packing as idx_in |
| idx_wb | output | NPORT*ADDR_W | Value to write back to the index register, same packing |

## Verification
The bench builds two copies with ADDR_W = 12, CNT_W = 4 and NPORT = 2: one with the precomputed-table reversal and one with the indexed-loop reversal, both checked against the same expected items. A 12-bit address with a 4-bit width field lets widths 13 to 15 be programmed, which brings the saturation rule within reach, and the 12-bit wrap of index plus step is easy to hit at the top of the range. Two ports let one vector mix reversed and plain, incremented and held operands, as in the four-bit example where indices 1 and 3 produce addresses 8 and 12 and write-backs 1 and 4.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

   // Reversal network variants selectable by parameter
   localparam int REV_LOOP  = 0;  // indexed loop over the live width
   localparam int REV_TABLE = 1;  // every width precomputed, then selected

   // Smallest field width able to hold the values 0..aw
   function automatic int cnt_bits(input int aw);
      return $clog2(aw + 1);
   endfunction

endpackage

// File: rtl/opaddr_cfg.sv
module opaddr_cfg #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_we,
   input  logic [ADDR_W-1:0] step_din,
   input  logic              width_we,
   input  logic [CNT_W-1:0]  width_din,
   output logic [ADDR_W-1:0] step_q,
   output logic [CNT_W-1:0]  width_eff
);

   localparam logic [CNT_W-1:0] WIDTH_MAX = CNT_W'(ADDR_W);
   localparam logic [ADDR_W-1:0] STEP_RST = ADDR_W'(1);

   logic [CNT_W-1:0] width_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= STEP_RST;
      end else if (step_we) begin
         step_q <= step_din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q <= '0;
      end else if (width_we) begin
         width_q <= width_din;
      end
   end

   // Widths past the address size mirror the whole address
   always_comb begin
      if (width_q > WIDTH_MAX) width_eff = WIDTH_MAX;
      else                     width_eff = width_q;
   end

   AST_STEP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      step_we |=> step_q == $past(step_din)); // R4
   AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_we |=> $stable(step_q)); // R4
   AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !width_we |=> $stable(width_eff)); // R11
   AST_WIDTH_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      width_we && (width_din > WIDTH_MAX) |=> width_eff == WIDTH_MAX); // R9

endmodule

// File: rtl/opaddr_bitrev.sv
module opaddr_bitrev #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 5,
   parameter int STYLE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] din,
   input  logic [CNT_W-1:0]  nbits,
   output logic [ADDR_W-1:0] dout
);

   import opaddr_pkg::*;

   logic [ADDR_W-1:0] mirrored;

   generate
      if (STYLE == REV_LOOP) begin : g_loop
         always_comb begin
            mirrored = din;
            for (int i = 0; i < ADDR_W; i++) begin
               if (i < int'(nbits)) mirrored[i] = din[int'(nbits) - 1 - i];
            end
         end
      end else begin : g_table
         logic [ADDR_W-1:0] cand [ADDR_W+1];
         for (genvar w = 0; w <= ADDR_W; w++) begin : g_w
            for (genvar b = 0; b < ADDR_W; b++) begin : g_b
               if (b < w) begin : g_in
                  assign cand[w][b] = din[w-1-b];
               end else begin : g_out
                  assign cand[w][b] = din[b];
               end
            end
         end
         always_comb begin
            mirrored = din;
            for (int w = 0; w <= ADDR_W; w++) begin
               if (nbits == CNT_W'(w)) mirrored = cand[w];
            end
         end
      end
   endgenerate

   assign dout = en ? mirrored : din;

   // Independent mask of the positions the reversal may touch
   logic [ADDR_W:0] span;
   assign span = ({{ADDR_W{1'b0}}, 1'b1} << nbits) - 1'b1;

   AST_REV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> dout == din); // R5
   AST_REV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $countones(dout) == $countones(din)); // R6
   AST_REV_HIGH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ((dout ^ din) & ~span[ADDR_W-1:0]) == '0); // R7
   AST_REV_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      en && (nbits < CNT_W'(2)) |-> dout == din); // R8

endmodule

// File: rtl/opaddr_lane.sv
module opaddr_lane #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 5,
   parameter int STYLE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] idx,
   input  logic              pinc,
   input  logic              rev,
   input  logic [ADDR_W-1:0] step,
   input  logic [CNT_W-1:0]  nbits,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] wb
);

   opaddr_bitrev #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .STYLE  (STYLE)
   ) u_rev (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (rev),
      .din   (idx),
      .nbits (nbits),
      .dout  (addr)
   );

   // Write-back taken from the index as presented, never from addr
   assign wb = pinc ? idx + step : idx;

   AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pinc |-> wb == idx); // R2
   AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pinc |-> ADDR_W'(wb - idx) == step); // R3
   AST_WB_PLAIN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      !rev && !pinc |-> addr == wb); // R10

endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit #(
   parameter int ADDR_W    = 16,
   parameter int NPORT     = 2,
   parameter int REV_STYLE = opaddr_pkg::REV_LOOP,
   parameter int CNT_W     = opaddr_pkg::cnt_bits(ADDR_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_step_we,
   input  logic [ADDR_W-1:0]       cfg_step_data,
   input  logic                    cfg_width_we,
   input  logic [CNT_W-1:0]        cfg_width_data,
   input  logic [NPORT*ADDR_W-1:0] idx_in,
   input  logic [NPORT-1:0]        post_inc,
   input  logic [NPORT-1:0]        rev_en,
   output logic [NPORT*ADDR_W-1:0] mem_addr,
   output logic [NPORT*ADDR_W-1:0] idx_wb
);

   import opaddr_pkg::*;

   localparam int MIN_CNT_W = cnt_bits(ADDR_W);

   generate
      if (ADDR_W < 2) begin : g_chk_aw
         $error("opaddr_unit: ADDR_W must be at least 2");
      end
      if (NPORT < 1) begin : g_chk_np
         $error("opaddr_unit: NPORT must be at least 1");
      end
      if (CNT_W < MIN_CNT_W) begin : g_chk_cw
         $error("opaddr_unit: CNT_W too narrow to express ADDR_W");
      end
      if (REV_STYLE != REV_LOOP && REV_STYLE != REV_TABLE) begin : g_chk_st
         $error("opaddr_unit: unknown REV_STYLE");
      end
   endgenerate

   logic [ADDR_W-1:0] step_q;
   logic [CNT_W-1:0]  width_eff;

   opaddr_cfg #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_we   (cfg_step_we),
      .step_din  (cfg_step_data),
      .width_we  (cfg_width_we),
      .width_din (cfg_width_data),
      .step_q    (step_q),
      .width_eff (width_eff)
   );

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         opaddr_lane #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .STYLE  (REV_STYLE)
         ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .idx   (idx_in[p*ADDR_W +: ADDR_W]),
            .pinc  (post_inc[p]),
            .rev   (rev_en[p]),
            .step  (step_q),
            .nbits (width_eff),
            .addr  (mem_addr[p*ADDR_W +: ADDR_W]),
            .wb    (idx_wb[p*ADDR_W +: ADDR_W])
         );
      end
   endgenerate

   AST_RESET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> step_q == ADDR_W'(1)); // R1
   AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      width_eff <= CNT_W'(ADDR_W)); // R9

endmodule

// File: tb/opaddr_unit_test.sv
`timescale 1ns/1ps
module opaddr_unit_test;

   localparam int AW = 12;
   localparam int NP = 2;
   localparam int CW = 4;

   typedef struct {
      logic [AW-1:0] addr [NP];
      logic [AW-1:0] wb   [NP];
      string         tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_step_we = 1'b0;
   logic [AW-1:0] cfg_step_data = '0;
   logic cfg_width_we = 1'b0;
   logic [CW-1:0] cfg_width_data = '0;
   logic [NP*AW-1:0] idx_in = '0;
   logic [NP-1:0] post_inc = '0;
   logic [NP-1:0] rev_en = '0;
   logic [NP*AW-1:0] addr_t, wb_t, addr_l, wb_l;

   int tests = 0;
   int fails = 0;
   item_t q [$];
   event  chk_ev;

   logic [AW-1:0] m_step;
   int            m_width;

   always #5 clk = ~clk;

   opaddr_unit #(.ADDR_W(AW), .NPORT(NP), .REV_STYLE(1), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_step_we(cfg_step_we), .cfg_step_data(cfg_step_data),
      .cfg_width_we(cfg_width_we), .cfg_width_data(cfg_width_data),
      .idx_in(idx_in), .post_inc(post_inc), .rev_en(rev_en),
      .mem_addr(addr_t), .idx_wb(wb_t));

   opaddr_unit #(.ADDR_W(AW), .NPORT(NP), .REV_STYLE(0), .CNT_W(CW)) uut_loop (
      .clk(clk), .rst_n(rst_n),
      .cfg_step_we(cfg_step_we), .cfg_step_data(cfg_step_data),
      .cfg_width_we(cfg_width_we), .cfg_width_data(cfg_width_data),
      .idx_in(idx_in), .post_inc(post_inc), .rev_en(rev_en),
      .mem_addr(addr_l), .idx_wb(wb_l));

   // Reference reversal from the requirement text
   function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v, input int n);
      logic [AW-1:0] r;
      int k;
      k = (n > AW) ? AW : n;
      r = v;
      for (int i = 0; i < k; i++) r[i] = v[k-1-i];
      return r;
   endfunction

   task automatic cmp(input string what, input string tag,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // Monitor: pops an expected item and compares both builds
   initial begin
      item_t it;
      forever begin
         @(chk_ev);
         it = q.pop_front();
         for (int p = 0; p < NP; p++) begin
            cmp($sformatf("table addr p%0d", p), it.tag, addr_t[p*AW +: AW], it.addr[p]);
            cmp($sformatf("table wb p%0d", p),   it.tag, wb_t[p*AW +: AW],   it.wb[p]);
            cmp($sformatf("loop addr p%0d", p),  it.tag, addr_l[p*AW +: AW], it.addr[p]);
            cmp($sformatf("loop wb p%0d", p),    it.tag, wb_l[p*AW +: AW],   it.wb[p]);
         end
      end
   end

   // Driver: applies a vector and queues what the requirements predict
   task automatic drive(input logic [AW-1:0] i0, input logic [AW-1:0] i1,
                        input logic [NP-1:0] pi, input logic [NP-1:0] rv,
                        input string tag);
      item_t it;
      logic [AW-1:0] iv [NP];
      iv[0] = i0;
      iv[1] = i1;
      @(negedge clk);
      idx_in   = {i1, i0};
      post_inc = pi;
      rev_en   = rv;
      for (int p = 0; p < NP; p++) begin
         it.addr[p] = rv[p] ? mirror(iv[p], m_width) : iv[p];
         it.wb[p]   = pi[p] ? AW'(iv[p] + m_step) : iv[p];
      end
      it.tag = tag;
      q.push_back(it);
      #2;
      ->chk_ev;
      #1;
   endtask

   task automatic set_step(input logic [AW-1:0] v, input logic we);
      @(negedge clk);
      cfg_step_we = we;
      cfg_step_data = v;
      @(posedge clk);
      #1;
      cfg_step_we = 1'b0;
      if (we) m_step = v;
   endtask

   task automatic set_width(input logic [CW-1:0] v, input logic we);
      @(negedge clk);
      cfg_width_we = we;
      cfg_width_data = v;
      @(posedge clk);
      #1;
      cfg_width_we = 1'b0;
      if (we) m_width = int'(v);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      m_step = AW'(1);
      m_width = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset values, step 1 and no reversal
      drive(12'h5A3, 12'h7FF, 2'b11, 2'b11, "R1");

      // R6 R3 R2 R10: four-bit example
      set_width(4'd4, 1'b1);
      set_step(12'h001, 1'b1);
      drive(12'h001, 12'h003, 2'b10, 2'b11, "R6");

      // R7: upper bits pass, R12: port 1 plain while port 0 reversed
      drive(12'hAB1, 12'hAB1, 2'b01, 2'b01, "R7");

      // R5 R2: reverse off on both
      drive(12'h123, 12'h456, 2'b00, 2'b00, "R5");

      // R8: widths 0 and 1 leave the address alone
      set_width(4'd1, 1'b1);
      drive(12'h801, 12'h002, 2'b00, 2'b11, "R8");
      set_width(4'd0, 1'b1);
      drive(12'h801, 12'h002, 2'b00, 2'b11, "R8");

      // R9: full width and beyond
      set_width(4'd12, 1'b1);
      drive(12'h001, 12'h0F3, 2'b00, 2'b11, "R9");
      set_width(4'd15, 1'b1);
      drive(12'h001, 12'h0F3, 2'b11, 2'b11, "R9");

      // R3: step change and wrap at the top of the range
      set_step(12'h100, 1'b1);
      drive(12'hF80, 12'hFFF, 2'b11, 2'b01, "R3");

      // R4 R11: writes without enable are ignored
      set_step(12'h00F, 1'b0);
      set_width(4'd3, 1'b0);
      drive(12'h00B, 12'hE05, 2'b11, 2'b11, "R4");
      drive(12'h00B, 12'hE05, 2'b01, 2'b10, "R11");

      // R10: same index, reverse toggled, write-back unchanged
      set_width(4'd6, 1'b1);
      set_step(12'h003, 1'b1);
      drive(12'h02D, 12'h02D, 2'b11, 2'b01, "R10");

      // R12: mixed patterns over many widths and steps
      for (int k = 0; k < 48; k++) begin
         if (k % 6 == 0) set_width(CW'(k / 3), 1'b1);
         if (k % 8 == 0) set_step(AW'(k * 37 + 5), 1'b1);
         drive(AW'(k * 291 + 17), AW'(k * 1433 + 900), NP'(k), NP'(k >> 2), "R12");
      end

      #20;
      summary();
   end

endmodule